// File: doc/BRIEF.md
# Redundant Link Failover Controller

This block decides which of two redundant data paths carries traffic. It watches the health of the path in use: a lock indication, per-frame CRC error pulses, a level that says the bit-error rate is too high, and a pulse that escalates an uncorrectable error. Transient trouble is filtered through windows and a post-recovery cooldown, so the selection does not bounce between paths. When policy allows, a bit-error-rate complaint first lowers the line rate, and the path is changed only if the complaint returns.

After any switch the controller waits for the new path to lock and gives up after a bounded time. A path that fails recovery or raises an uncorrectable error is retired. It stays retired until an explicit requalify command names it. With both paths retired the controller parks in a safe state and raises an alarm. Every decision is reported as a one-cycle event carrying a cause code, an outcome code, the resulting path and a free-running cycle timestamp.

Top module: `link_failover_ctl`

## Requirements
- R1: An `ue_esc` pulse, outside the safe state and regardless of cooldown, produces in the next cycle an event with cause 1. It retires the current path. It selects the other path (outcome 0) if that path is not retired, and enters the safe state (outcome 3) otherwise.
- R2: In the run state with no cooldown pending, `link_up` low starts recovery. If the other path is usable it is selected (cause 2, outcome 0). Otherwise the current path is kept and awaits relock (cause 2, outcome 2).
- R3: While awaiting relock, `link_up` high logs cause 6, outcome 4, returns to the run state and loads the cooldown counter with `cfg_cool`.
- R4: CRC errors are debounced. A window opens at the first error pulse and lasts `cfg_crc_win` cycles. The trigger fires on the pulse that brings the count inside the window to `cfg_crc_thr`. Fewer pulses leave the path unchanged and log nothing.
- R5: `ber_high` is counted per cycle over a window in the same way (`cfg_ber_win`, `cfg_ber_thr`). With `cfg_rate_first` set and the rate not yet lowered, a trigger raises `rate_low` and logs cause 4, outcome 1 without switching. A later trigger switches the path (outcome 0), and every path switch clears `rate_low`.
- R6: While cooldown is pending in the run state, only an `ue_esc` pulse may change the path. CRC or BER triggers log outcome 2, and loss of lock is not acted on.
- R7: If no relock arrives within `cfg_relock_tmo` cycles of entering recovery, a failed-recovery event is logged (cause 5) and the path is retired. The controller moves to the other path if it is usable (outcome 0) and to the safe state otherwise (outcome 3).
- R8: A retired path is never reselected until a `requal` pulse names it through `requal_path`. That pulse clears the retirement and logs cause 7, outcome 4.
- R9: In the safe state `alarm` is high and both paths are retired. A `requal` pulse selects the named path, starts recovery and logs cause 7, outcome 0.
- R10: `evt_valid` is a one-cycle pulse. `evt_time` is a cycle counter, so the difference between two events' timestamps equals the number of cycles between them.
- R11: After reset path 0 is selected, `rate_low`, `alarm` and `evt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Lock indication of the selected path |
| crc_err | input | 1 | One pulse per frame with a CRC failure |
| ber_high | input | 1 | Bit-error rate above threshold (level) |
| ue_esc | input | 1 | Uncorrectable-error escalation pulse |
| requal | input | 1 | Requalify command pulse |
| requal_path | input | 1 | Path named by the requalify command |
| cfg_crc_win | input | WIN_W | CRC window length in cycles |
| cfg_crc_thr | input | WIN_W | CRC errors needed inside the window (at least 1) |
| cfg_ber_win | input | WIN_W | BER window length in cycles |
| cfg_ber_thr | input | WIN_W | BER-high cycles needed inside the window (at least 1) |
| cfg_cool | input | TMR_W | Cooldown after relock, in cycles |
| cfg_relock_tmo | input | TMR_W | Relock timeout, in cycles (at least 1) |
| cfg_rate_first | input | 1 | Try rate reduction before switching on BER |
| path_sel | output | 1 | Selected path |
| rate_low | output | 1 | Reduced line rate request |
| alarm | output | 1 | Safe state, both paths retired |
| evt_valid | output | 1 | Event pulse |
| evt_cause | output | 3 | Event cause code |
| evt_outcome | output | 3 | Event outcome code |
| evt_path | output | 1 | Path selected after the decision |
| evt_time | output | TS_W | Cycle timestamp of the decision |

## Verification
A stale retirement bit or a wrong recovery state shows up at the ports at the next health complaint. The complaint either fails to switch `path_sel` or lands on a retired path, and the event record carries the wrong outcome code one cycle later. A window counter that is not cleared shows as a CRC or BER event that fires early or late relative to the pulse pattern. A timeout or cooldown counter that is off by one shifts the failed-recovery timestamp or lets a switch happen inside the cooldown, visible within `cfg_relock_tmo` or `cfg_cool` cycles.

// File: rtl/lfo_pkg.sv
package lfo_pkg;
  typedef enum logic [1:0] {S_RUN = 2'd0, S_RESYNC = 2'd1, S_SAFE = 2'd2} lfo_state_e;

  typedef enum logic [2:0] {
    C_NONE = 3'd0, C_UE = 3'd1, C_LOCK = 3'd2, C_CRC = 3'd3,
    C_BER = 3'd4, C_RFAIL = 3'd5, C_RELOCK = 3'd6, C_REQUAL = 3'd7
  } lfo_cause_e;

  typedef enum logic [2:0] {
    O_SWITCH = 3'd0, O_RATE = 3'd1, O_HELD = 3'd2, O_SAFE = 3'd3, O_OK = 3'd4
  } lfo_outcome_e;
endpackage

// File: rtl/lfo_win.sv
module lfo_win #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] thr,
  output logic          fire
);
  logic          open_q;
  logic [CW:0]   age_q;
  logic [CW-1:0] cnt_q;
  logic          live;
  logic [CW:0]   cnt_nx;

  function automatic logic [CW:0] next_count(input logic inwin, input logic [CW-1:0] c,
                                             input logic h);
    return (inwin ? {1'b0, c} : '0) + {{CW{1'b0}}, h};
  endfunction

  assign live   = open_q && (age_q < {1'b0, win_len});
  assign cnt_nx = next_count(live, cnt_q, hit);
  assign fire   = hit && (cnt_nx >= {1'b0, thr});

  always_ff @(posedge clk) begin
    if (!rst_n || clr || fire) begin
      open_q <= 1'b0;
      age_q  <= '0;
      cnt_q  <= '0;
    end else if (live) begin
      age_q <= age_q + 1'b1;
      cnt_q <= cnt_nx[CW-1:0];
    end else if (hit) begin
      open_q <= 1'b1;
      age_q  <= {{CW{1'b0}}, 1'b1};
      cnt_q  <= {{(CW-1){1'b0}}, 1'b1};
    end else begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end
  end

  // R4
  cnt_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < thr);
endmodule

// File: rtl/lfo_evt.sv
module lfo_evt #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            log_en,
  input  logic [2:0]      cause,
  input  logic [2:0]      outc,
  input  logic            path,
  output logic            evt_valid,
  output logic [2:0]      evt_cause,
  output logic [2:0]      evt_outcome,
  output logic            evt_path,
  output logic [TS_W-1:0] evt_time
);
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q        <= '0;
      evt_valid   <= 1'b0;
      evt_cause   <= '0;
      evt_outcome <= '0;
      evt_path    <= 1'b0;
      evt_time    <= '0;
    end else begin
      ts_q      <= ts_q + 1'b1;
      evt_valid <= log_en;
      if (log_en) begin
        evt_cause   <= cause;
        evt_outcome <= outc;
        evt_path    <= path;
        evt_time    <= ts_q;
      end
    end
  end

  // R10
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && $past(evt_valid)) |-> (evt_time == $past(evt_time) + 1'b1));
endmodule

// File: rtl/link_failover_ctl.sv
module link_failover_ctl
  import lfo_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int TMR_W = 12,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             crc_err,
  input  logic             ber_high,
  input  logic             ue_esc,
  input  logic             requal,
  input  logic             requal_path,
  input  logic [WIN_W-1:0] cfg_crc_win,
  input  logic [WIN_W-1:0] cfg_crc_thr,
  input  logic [WIN_W-1:0] cfg_ber_win,
  input  logic [WIN_W-1:0] cfg_ber_thr,
  input  logic [TMR_W-1:0] cfg_cool,
  input  logic [TMR_W-1:0] cfg_relock_tmo,
  input  logic             cfg_rate_first,
  output logic             path_sel,
  output logic             rate_low,
  output logic             alarm,
  output logic             evt_valid,
  output logic [2:0]       evt_cause,
  output logic [2:0]       evt_outcome,
  output logic             evt_path,
  output logic [TS_W-1:0]  evt_time
);
  lfo_state_e       st_q, nx_st;
  logic             path_q, nx_path;
  logic [1:0]       lock_q, nx_lock;
  logic             rate_q, nx_rate;
  logic [TMR_W-1:0] cool_q, nx_cool, tmo_q, nx_tmo;
  logic             log_en;
  lfo_cause_e       cause;
  lfo_outcome_e     outc;
  logic             crc_fire, ber_fire, win_clr;
  logic             other_ok, cool_busy, tmo_hit;

  function automatic logic [TMR_W-1:0] count_down(input logic [TMR_W-1:0] v);
    return (v != '0) ? v - 1'b1 : '0;
  endfunction

  function automatic logic timeout_reached(input logic [TMR_W-1:0] t, input logic [TMR_W-1:0] lim);
    return ({1'b0, t} + 1'b1) >= {1'b0, lim};
  endfunction

  assign other_ok  = !lock_q[~path_q];
  assign cool_busy = (cool_q != '0);
  assign tmo_hit   = timeout_reached(tmo_q, cfg_relock_tmo);
  assign win_clr   = (st_q != S_RUN) || log_en;

  lfo_win #(.CW(WIN_W)) crc_win_i (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .hit(crc_err),
    .win_len(cfg_crc_win), .thr(cfg_crc_thr), .fire(crc_fire));

  lfo_win #(.CW(WIN_W)) ber_win_i (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .hit(ber_high),
    .win_len(cfg_ber_win), .thr(cfg_ber_thr), .fire(ber_fire));

  always_comb begin
    nx_st   = st_q;
    nx_path = path_q;
    nx_lock = lock_q;
    nx_rate = rate_q;
    nx_cool = count_down(cool_q);
    nx_tmo  = tmo_q;
    log_en  = 1'b0;
    cause   = C_NONE;
    outc    = O_OK;
    if (st_q != S_SAFE && ue_esc) begin
      log_en = 1'b1;
      cause  = C_UE;
      nx_lock[path_q] = 1'b1;
      if (other_ok) begin
        nx_path = ~path_q; nx_st = S_RESYNC; nx_tmo = '0; nx_rate = 1'b0; outc = O_SWITCH;
      end else begin
        nx_st = S_SAFE; outc = O_SAFE;
      end
    end else if (st_q == S_RESYNC) begin
      if (link_up) begin
        log_en = 1'b1; cause = C_RELOCK; outc = O_OK;
        nx_st = S_RUN; nx_cool = cfg_cool;
      end else if (tmo_hit) begin
        log_en = 1'b1; cause = C_RFAIL;
        nx_lock[path_q] = 1'b1;
        if (other_ok) begin
          nx_path = ~path_q; nx_tmo = '0; nx_rate = 1'b0; outc = O_SWITCH;
        end else begin
          nx_st = S_SAFE; outc = O_SAFE;
        end
      end else begin
        nx_tmo = tmo_q + 1'b1;
      end
    end else if (st_q == S_RUN && !link_up && !cool_busy) begin
      log_en = 1'b1; cause = C_LOCK; nx_st = S_RESYNC; nx_tmo = '0;
      if (other_ok) begin
        nx_path = ~path_q; nx_rate = 1'b0; outc = O_SWITCH;
      end else begin
        outc = O_HELD;
      end
    end else if (st_q == S_RUN && (crc_fire || ber_fire)) begin
      log_en = 1'b1;
      cause  = crc_fire ? C_CRC : C_BER;
      if (!crc_fire && cfg_rate_first && !rate_q) begin
        nx_rate = 1'b1; outc = O_RATE;
      end else if (cool_busy || !other_ok) begin
        outc = O_HELD;
      end else begin
        nx_path = ~path_q; nx_st = S_RESYNC; nx_tmo = '0; nx_rate = 1'b0; outc = O_SWITCH;
      end
    end else if (requal) begin
      log_en = 1'b1; cause = C_REQUAL;
      nx_lock[requal_path] = 1'b0;
      if (st_q == S_SAFE) begin
        nx_path = requal_path; nx_st = S_RESYNC; nx_tmo = '0; nx_rate = 1'b0; outc = O_SWITCH;
      end else begin
        outc = O_OK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_RUN;
      path_q <= 1'b0;
      lock_q <= '0;
      rate_q <= 1'b0;
      cool_q <= '0;
      tmo_q  <= '0;
    end else begin
      st_q   <= nx_st;
      path_q <= nx_path;
      lock_q <= nx_lock;
      rate_q <= nx_rate;
      cool_q <= nx_cool;
      tmo_q  <= nx_tmo;
    end
  end

  lfo_evt #(.TS_W(TS_W)) evt_i (
    .clk(clk), .rst_n(rst_n), .log_en(log_en), .cause(cause), .outc(outc),
    .path(nx_path), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .evt_outcome(evt_outcome), .evt_path(evt_path), .evt_time(evt_time));

  assign path_sel = path_q;
  assign rate_low = rate_q;
  assign alarm    = (st_q == S_SAFE);

  // R1
  ue_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_esc && st_q != S_SAFE) |=> (evt_valid && evt_cause == 3'd1));
  // R5
  rate_clear_on_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_q != $past(path_q)) |-> !rate_q);
  // R6
  no_switch_in_cool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && cool_busy && !ue_esc) |=> (path_q == $past(path_q)));
  // R8
  sel_not_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_SAFE) |-> !lock_q[path_q]);
  // R9
  safe_all_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SAFE) |-> (&lock_q));
endmodule

// File: tb/link_failover_ctl_tb_top.sv
module link_failover_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // win, thr, pulse count, pulse spacing, expect trigger
  localparam logic [32:0] CRC_VEC [NVEC] = '{
    {8'd8,  8'd3, 8'd3, 8'd1, 1'b1},
    {8'd8,  8'd3, 8'd2, 8'd1, 1'b0},
    {8'd8,  8'd3, 8'd3, 8'd4, 1'b0},
    {8'd8,  8'd3, 8'd3, 8'd3, 1'b1},
    {8'd4,  8'd1, 8'd1, 8'd1, 1'b1},
    {8'd5,  8'd4, 8'd5, 8'd2, 1'b0},
    {8'd16, 8'd4, 8'd4, 8'd5, 1'b1},
    {8'd15, 8'd4, 8'd4, 8'd5, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b1, crc_err = 1'b0, ber_high = 1'b0, ue_esc = 1'b0;
  logic requal = 1'b0, requal_path = 1'b0;
  logic [7:0]  cfg_crc_win = 8'd8, cfg_crc_thr = 8'd3, cfg_ber_win = 8'd8, cfg_ber_thr = 8'd3;
  logic [11:0] cfg_cool = '0, cfg_relock_tmo = 12'd10;
  logic        cfg_rate_first = 1'b0;
  logic        path_sel, rate_low, alarm, evt_valid, evt_path;
  logic [2:0]  evt_cause, evt_outcome;
  logic [31:0] evt_time;

  int errs = 0, checks = 0, cyc = 0, nev = 0;
  int first_cause, first_out, first_path;
  int prev_cyc;
  bit have_prev;
  logic [31:0] prev_time;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_failover_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .crc_err(crc_err), .ber_high(ber_high),
    .ue_esc(ue_esc), .requal(requal), .requal_path(requal_path),
    .cfg_crc_win(cfg_crc_win), .cfg_crc_thr(cfg_crc_thr), .cfg_ber_win(cfg_ber_win),
    .cfg_ber_thr(cfg_ber_thr), .cfg_cool(cfg_cool), .cfg_relock_tmo(cfg_relock_tmo),
    .cfg_rate_first(cfg_rate_first), .path_sel(path_sel), .rate_low(rate_low), .alarm(alarm),
    .evt_valid(evt_valid), .evt_cause(evt_cause), .evt_outcome(evt_outcome),
    .evt_path(evt_path), .evt_time(evt_time));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (evt_valid) begin
      if (nev == 0) begin
        first_cause = evt_cause; first_out = evt_outcome; first_path = evt_path;
      end
      if (have_prev)
        chk((evt_time - prev_time) == 32'(cyc - prev_cyc), "R10 timestamp spacing",
            evt_time - prev_time, cyc - prev_cyc);
      have_prev = 1'b1; prev_time = evt_time; prev_cyc = cyc;
      nev++;
    end
  endtask

  task automatic do_reset(input logic [7:0] cw, input logic [7:0] ct,
                          input logic [11:0] cool, input logic rf);
    rst_n = 1'b0;
    cfg_crc_win = cw; cfg_crc_thr = ct; cfg_ber_win = 8'd8; cfg_ber_thr = 8'd3;
    cfg_cool = cool; cfg_relock_tmo = 12'd10; cfg_rate_first = rf;
    link_up = 1'b1; crc_err = 1'b0; ber_high = 1'b0; ue_esc = 1'b0; requal = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nev = 0; have_prev = 1'b0;
  endtask

  task automatic expect_evt(input string tag, input int c, input int o, input int p);
    chk(evt_valid == 1'b1, {tag, " event valid"}, evt_valid, 1);
    chk(evt_cause == 3'(c), {tag, " cause"}, evt_cause, c);
    chk(evt_outcome == 3'(o), {tag, " outcome"}, evt_outcome, o);
    chk(path_sel == p[0], {tag, " path"}, path_sel, p);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int n0;
    int t_ue;
    // R11 reset state
    do_reset(8'd8, 8'd3, 12'd0, 1'b0);
    tick();
    chk(path_sel == 1'b0, "R11 path after reset", path_sel, 0);
    chk(rate_low == 1'b0, "R11 rate after reset", rate_low, 0);
    chk(alarm == 1'b0, "R11 alarm after reset", alarm, 0);
    chk(evt_valid == 1'b0, "R11 no event after reset", evt_valid, 0);

    // R4 CRC debounce table
    for (int v = 0; v < NVEC; v++) begin
      do_reset(CRC_VEC[v][32:25], CRC_VEC[v][24:17], 12'd0, 1'b0);
      for (int k = 0; k < int'(CRC_VEC[v][16:9]); k++) begin
        crc_err = 1'b1; tick(); crc_err = 1'b0;
        for (int g = 1; g < int'(CRC_VEC[v][8:1]); g++) tick();
      end
      repeat (3) tick();
      if (CRC_VEC[v][0]) begin
        chk(first_cause == 3 && first_out == 0, "R4 crc trigger cause/outcome",
            first_cause * 8 + first_out, 24);
        chk(path_sel == 1'b1, "R4 crc trigger path", path_sel, 1);
      end else begin
        chk(nev == 0, "R4 short burst ignored, events", nev, 0);
        chk(path_sel == 1'b0, "R4 short burst ignored, path", path_sel, 0);
      end
    end

    // R5 rate reduction before switch
    do_reset(8'd8, 8'd3, 12'd0, 1'b1);
    ber_high = 1'b1; repeat (2) tick();
    chk(nev == 0, "R5 no trigger before threshold", nev, 0);
    tick(); ber_high = 1'b0;
    expect_evt("R5 rate step", 4, 1, 0);
    chk(rate_low == 1'b1, "R5 rate lowered", rate_low, 1);
    tick();
    ber_high = 1'b1; repeat (3) tick(); ber_high = 1'b0;
    expect_evt("R5 second trigger switch", 4, 0, 1);
    chk(rate_low == 1'b0, "R5 rate cleared on switch", rate_low, 0);
    tick();
    expect_evt("R3 relock after ber switch", 6, 4, 1);

    // R2, R3, R6, R1, R8
    do_reset(8'd8, 8'd3, 12'd20, 1'b0);
    link_up = 1'b0; tick();
    expect_evt("R2 lock loss switch", 2, 0, 1);
    link_up = 1'b1; tick();
    expect_evt("R3 relock", 6, 4, 1);
    crc_err = 1'b1; repeat (3) tick(); crc_err = 1'b0;
    expect_evt("R6 crc held in cooldown", 3, 2, 1);
    n0 = nev;
    link_up = 1'b0; repeat (2) tick(); link_up = 1'b1;
    chk(nev == n0, "R6 lock loss ignored in cooldown, events", nev, n0);
    chk(path_sel == 1'b1, "R6 lock loss ignored in cooldown, path", path_sel, 1);
    ue_esc = 1'b1; tick(); ue_esc = 1'b0;
    expect_evt("R1 ue overrides cooldown", 1, 0, 0);
    tick();
    expect_evt("R3 relock after ue", 6, 4, 0);
    repeat (25) tick();
    link_up = 1'b0; tick();
    expect_evt("R8 retired path not reselected", 2, 2, 0);
    link_up = 1'b1; tick();
    expect_evt("R3 relock same path", 6, 4, 0);
    repeat (25) tick();
    requal_path = 1'b1; requal = 1'b1; tick(); requal = 1'b0;
    expect_evt("R8 requalify", 7, 4, 0);
    link_up = 1'b0; tick();
    expect_evt("R8 requalified path usable", 2, 0, 1);
    link_up = 1'b1; tick();

    // R7, R9 timeout into safe state, requalify out
    do_reset(8'd8, 8'd3, 12'd0, 1'b0);
    link_up = 1'b0; ue_esc = 1'b1; tick(); ue_esc = 1'b0;
    expect_evt("R1 ue switch", 1, 0, 1);
    t_ue = cyc;
    n0 = nev;
    repeat (9) tick();
    chk(nev == n0, "R7 no event before timeout", nev, n0);
    chk(alarm == 1'b0, "R7 no alarm before timeout", alarm, 0);
    tick();
    expect_evt("R7 failed recovery to safe", 5, 3, 1);
    chk(cyc - t_ue == 10, "R7 timeout length", cyc - t_ue, 10);
    chk(alarm == 1'b1, "R9 alarm in safe state", alarm, 1);
    requal_path = 1'b1; requal = 1'b1; tick(); requal = 1'b0;
    expect_evt("R9 requalify leaves safe", 7, 0, 1);
    chk(alarm == 1'b0, "R9 alarm cleared", alarm, 0);
    link_up = 1'b1; tick();
    expect_evt("R3 relock after requalify", 6, 4, 1);

    // R7 timeout with switch
    do_reset(8'd8, 8'd3, 12'd0, 1'b0);
    link_up = 1'b0; tick();
    expect_evt("R2 lock loss switch", 2, 0, 1);
    repeat (10) tick();
    expect_evt("R7 failed recovery switch", 5, 0, 0);
    link_up = 1'b1; tick();
    expect_evt("R3 relock after failed recovery", 6, 4, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule